// File: doc/BRIEF.md
# Multicycle Shared-ALU Datapath

This block executes a small load/store instruction set over several clock cycles, with a single arithmetic unit doing all of the computing. That one unit produces the incremented program counter during fetch and the branch target during decode. In the execute step it computes the instruction's result, the memory address or the branch comparison. Each instruction walks through fetch, register read, execute, and where needed a memory step and a register write-back step. An internal sequencer drives every multiplexer select and register enable from the state and the opcode.

Program and data memory are outside the block and share one port set. The block presents an address, write data and a write strobe. It expects the read data to arrive combinationally in the same cycle. The register file, the operand registers A and B, the instruction register, the result register, the load data register and the program counter are all inside. The number of registers, the reset address and whether register 0 is hardwired are parameters.

Top module: `mcdp_core`

## Requirements
- R1: While reset is low and in the first cycle after it, mem_addr equals PC_RESET and mem_we is 0. All registers of the register file reset to zero.
- R2: Opcode 000000 is register format and writes rd. Its ALU operation comes from instruction bits [2:0]: 000 and, 001 or, 010 add, 110 subtract (rs minus rt), 101 shift left, 111 logical shift right. Codes 011 and 100 give zero.
- R3: Opcodes 001fff are immediate operations. fff uses the same codes as R2, the second operand is the sign-extended bits [15:0], and the result goes to rt.
- R4: Both shifts move the rs operand by exactly one bit. The shamt field (bits [10:6]) and the second operand are ignored.
- R5: Register-format and immediate instructions take four cycles: fetch (PC+4 through the ALU), register read into A and B, execute into the result register, and register write-back. The next fetch comes in the fifth cycle.
- R6: beq (opcode 000100) takes three cycles. In its third cycle, if rs equals rt, it loads PC with PC+4 plus the sign-extended bits [15:0] shifted left by two, so the next fetch uses that address. Otherwise the next fetch uses PC+4.
- R7: bne (opcode 000101) behaves as R6 but branches when rs differs from rt.
- R8: j (opcode 000010) takes three cycles. It loads PC with the upper four bits of PC+4 followed by bits [25:0] and two zero bits.
- R9: lw (opcode 100011) takes five cycles. In the fourth it drives mem_addr = rs + sign-extended bits [15:0] with mem_we low. In the fifth it writes the read word into rt.
- R10: sw (opcode 101011) takes four cycles. mem_we is high in the fourth cycle only, with mem_addr = rs + sign-extended bits [15:0] and mem_wdata = rt.
- R11: With R0_IS_ZERO set, register 0 always reads zero and writes to it are discarded.
- R12: Any other opcode takes three cycles and writes neither a register nor memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mem_addr | output | 32 | Memory byte address: PC in fetch, result register in the memory step |
| mem_wdata | output | 32 | Store data (register B) |
| mem_rdata | input | 32 | Combinational read data from memory |
| mem_we | output | 1 | Memory write strobe |

## Verification
The bench builds the block with REG_CNT = 32 and R0_IS_ZERO = 1, so every 5-bit register field is exercised and register 0 is hardwired. PC_RESET is set to 32'h1000_0000. With a non-zero upper nibble in the program counter, the jump check can show that the top four address bits are kept rather than cleared. Data addresses near zero are reached by adding the immediate to register 0, so instruction and data regions differ in their upper bits while the bench memory decodes only bits [9:2].

// File: rtl/mcdp_pkg.sv
package mcdp_pkg;

   localparam int XLEN = 32;

   localparam logic [5:0] OP_RFMT = 6'b000000;
   localparam logic [5:0] OP_JMP  = 6'b000010;
   localparam logic [5:0] OP_BEQ  = 6'b000100;
   localparam logic [5:0] OP_BNE  = 6'b000101;
   localparam logic [5:0] OP_LDW  = 6'b100011;
   localparam logic [5:0] OP_STW  = 6'b101011;
   localparam logic [2:0] OP_IMM_GRP = 3'b001;

   localparam logic [2:0] ALU_AND = 3'b000;
   localparam logic [2:0] ALU_OR  = 3'b001;
   localparam logic [2:0] ALU_ADD = 3'b010;
   localparam logic [2:0] ALU_SHL = 3'b101;
   localparam logic [2:0] ALU_SUB = 3'b110;
   localparam logic [2:0] ALU_SHR = 3'b111;

   typedef enum logic [2:0] {
      ST_FETCH, ST_DECODE, ST_EXEC, ST_MEM, ST_WB
   } state_e;

   typedef enum logic {ASEL_PC, ASEL_REG} a_sel_e;
   typedef enum logic [1:0] {BSEL_REG, BSEL_FOUR, BSEL_IMM, BSEL_IMMSH} b_sel_e;
   typedef enum logic [1:0] {PCS_ALU, PCS_ALUOUT, PCS_JUMP} pc_src_e;

   typedef struct packed {
      logic       pc_we;
      logic       br_eq;
      logic       br_ne;
      pc_src_e    pc_src;
      logic       ir_we;
      logic       addr_res;
      logic       mem_we;
      logic       mdr_we;
      logic       ab_we;
      a_sel_e     a_sel;
      b_sel_e     b_sel;
      logic [2:0] alu_op;
      logic       res_we;
      logic       rf_we;
      logic       dst_rd;
      logic       wsrc_mdr;
   } ctrl_t;

endpackage

// File: rtl/mcdp_alu.sv
module mcdp_alu #(
   parameter int W     = 32,
   parameter int SHIFT = 1
) (
   input  logic [2:0]   op,
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   output logic [W-1:0] y,
   output logic         zero
);
   import mcdp_pkg::*;

   generate
      if (SHIFT < 1 || SHIFT >= W) begin : g_bad_shift
         $error("mcdp_alu: SHIFT must lie in 1..W-1");
      end
   endgenerate

   always_comb begin
      case (op)
         ALU_AND: y = a & b;
         ALU_OR:  y = a | b;
         ALU_ADD: y = a + b;
         ALU_SUB: y = a - b;
         ALU_SHL: y = a << SHIFT;
         ALU_SHR: y = a >> SHIFT;
         default: y = '0;
      endcase
   end

   assign zero = (y == '0);

endmodule

// File: rtl/mcdp_regfile.sv
module mcdp_regfile #(
   parameter int W       = 32,
   parameter int DEPTH   = 32,
   parameter bit R0_ZERO = 1'b1,
   localparam int AW     = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [AW-1:0] ra1,
   input  logic [AW-1:0] ra2,
   output logic [W-1:0]  rd1,
   output logic [W-1:0]  rd2,
   input  logic          we,
   input  logic [AW-1:0] wa,
   input  logic [W-1:0]  wd
);

   generate
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("mcdp_regfile: DEPTH must be a power of two, at least 2");
      end
   endgenerate

   logic [W-1:0] slot [DEPTH];

   generate
      for (genvar i = 0; i < DEPTH; i++) begin : g_slot
         if (R0_ZERO && i == 0) begin : g_tied
            assign slot[i] = '0;
         end else begin : g_flop
            logic [W-1:0] q;
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n)
                  q <= '0;
               else if (we && wa == AW'(i))
                  q <= wd;
            end
            assign slot[i] = q;
         end
      end
   endgenerate

   assign rd1 = slot[ra1];
   assign rd2 = slot[ra2];

endmodule

// File: rtl/mcdp_ctrl.sv
module mcdp_ctrl
   import mcdp_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic [5:0] opcode,
   input  logic [2:0] funct3,
   output state_e     state,
   output ctrl_t      cs
);

   state_e nxt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         state <= ST_FETCH;
      else
         state <= nxt;
   end

   always_comb begin
      cs  = '0;
      nxt = state;
      case (state)
         ST_FETCH: begin
            cs.ir_we  = 1'b1;
            cs.a_sel  = ASEL_PC;
            cs.b_sel  = BSEL_FOUR;
            cs.alu_op = ALU_ADD;
            cs.pc_we  = 1'b1;
            cs.pc_src = PCS_ALU;
            nxt       = ST_DECODE;
         end
         ST_DECODE: begin
            cs.ab_we  = 1'b1;
            cs.a_sel  = ASEL_PC;
            cs.b_sel  = BSEL_IMMSH;
            cs.alu_op = ALU_ADD;
            cs.res_we = 1'b1;
            nxt       = ST_EXEC;
         end
         ST_EXEC: begin
            cs.a_sel = ASEL_REG;
            nxt      = ST_FETCH;
            if (opcode == OP_RFMT) begin
               cs.b_sel  = BSEL_REG;
               cs.alu_op = funct3;
               cs.res_we = 1'b1;
               nxt       = ST_WB;
            end else if (opcode[5:3] == OP_IMM_GRP) begin
               cs.b_sel  = BSEL_IMM;
               cs.alu_op = opcode[2:0];
               cs.res_we = 1'b1;
               nxt       = ST_WB;
            end else if (opcode == OP_LDW || opcode == OP_STW) begin
               cs.b_sel  = BSEL_IMM;
               cs.alu_op = ALU_ADD;
               cs.res_we = 1'b1;
               nxt       = ST_MEM;
            end else if (opcode == OP_BEQ || opcode == OP_BNE) begin
               cs.b_sel  = BSEL_REG;
               cs.alu_op = ALU_SUB;
               cs.br_eq  = (opcode == OP_BEQ);
               cs.br_ne  = (opcode == OP_BNE);
               cs.pc_src = PCS_ALUOUT;
            end else if (opcode == OP_JMP) begin
               cs.pc_we  = 1'b1;
               cs.pc_src = PCS_JUMP;
            end
         end
         ST_MEM: begin
            cs.addr_res = 1'b1;
            if (opcode == OP_LDW) begin
               cs.mdr_we = 1'b1;
               nxt       = ST_WB;
            end else begin
               cs.mem_we = 1'b1;
               nxt       = ST_FETCH;
            end
         end
         ST_WB: begin
            cs.rf_we    = 1'b1;
            cs.dst_rd   = (opcode == OP_RFMT);
            cs.wsrc_mdr = (opcode == OP_LDW);
            nxt         = ST_FETCH;
         end
         default: nxt = ST_FETCH;
      endcase
   end

endmodule

// File: rtl/mcdp_core.sv
module mcdp_core
   import mcdp_pkg::*;
#(
   parameter int              REG_CNT    = 32,
   parameter logic [XLEN-1:0] PC_RESET   = '0,
   parameter bit              R0_IS_ZERO = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   output logic [XLEN-1:0] mem_addr,
   output logic [XLEN-1:0] mem_wdata,
   input  logic [XLEN-1:0] mem_rdata,
   output logic            mem_we
);

   localparam int RAW = $clog2(REG_CNT);

   generate
      if (REG_CNT < 2 || REG_CNT > 32) begin : g_bad_regcnt
         $error("mcdp_core: REG_CNT must lie in 2..32");
      end
      if (PC_RESET[1:0] != 2'b00) begin : g_bad_pcreset
         $error("mcdp_core: PC_RESET must be word aligned");
      end
   endgenerate

   state_e          st_q;
   ctrl_t           cs;
   logic [XLEN-1:0] pc_q, ir_q, a_q, b_q, aluout_q, mdr_q;
   logic [XLEN-1:0] alu_a, alu_b, alu_y, pc_nx;
   logic [XLEN-1:0] imm_sx, imm_sh, jmp_tgt;
   logic [XLEN-1:0] rf_rd1, rf_rd2, rf_wd;
   logic [RAW-1:0]  rs_idx, rt_idx, rd_idx, rf_wa;
   logic            alu_zero, pc_wr;

   assign rs_idx  = ir_q[21 +: RAW];
   assign rt_idx  = ir_q[16 +: RAW];
   assign rd_idx  = ir_q[11 +: RAW];
   assign imm_sx  = {{(XLEN-16){ir_q[15]}}, ir_q[15:0]};
   assign imm_sh  = {imm_sx[XLEN-3:0], 2'b00};
   assign jmp_tgt = {pc_q[XLEN-1:XLEN-4], ir_q[25:0], 2'b00};

   mcdp_ctrl u_ctrl (
      .clk    (clk),
      .rst_n  (rst_n),
      .opcode (ir_q[31:26]),
      .funct3 (ir_q[2:0]),
      .state  (st_q),
      .cs     (cs)
   );

   always_comb begin
      case (cs.a_sel)
         ASEL_PC: alu_a = pc_q;
         default: alu_a = a_q;
      endcase
      case (cs.b_sel)
         BSEL_REG:  alu_b = b_q;
         BSEL_FOUR: alu_b = XLEN'(4);
         BSEL_IMM:  alu_b = imm_sx;
         default:   alu_b = imm_sh;
      endcase
      case (cs.pc_src)
         PCS_ALUOUT: pc_nx = aluout_q;
         PCS_JUMP:   pc_nx = jmp_tgt;
         default:    pc_nx = alu_y;
      endcase
   end

   mcdp_alu #(.W(XLEN), .SHIFT(1)) u_alu (
      .op   (cs.alu_op),
      .a    (alu_a),
      .b    (alu_b),
      .y    (alu_y),
      .zero (alu_zero)
   );

   assign pc_wr = cs.pc_we | (cs.br_eq & alu_zero) | (cs.br_ne & ~alu_zero);
   assign rf_wa = cs.dst_rd   ? rd_idx : rt_idx;
   assign rf_wd = cs.wsrc_mdr ? mdr_q  : aluout_q;

   mcdp_regfile #(.W(XLEN), .DEPTH(REG_CNT), .R0_ZERO(R0_IS_ZERO)) u_rf (
      .clk   (clk),
      .rst_n (rst_n),
      .ra1   (rs_idx),
      .ra2   (rt_idx),
      .rd1   (rf_rd1),
      .rd2   (rf_rd2),
      .we    (cs.rf_we),
      .wa    (rf_wa),
      .wd    (rf_wd)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pc_q     <= PC_RESET;
         ir_q     <= '0;
         a_q      <= '0;
         b_q      <= '0;
         aluout_q <= '0;
         mdr_q    <= '0;
      end else begin
         if (pc_wr)     pc_q     <= pc_nx;
         if (cs.ir_we)  ir_q     <= mem_rdata;
         if (cs.ab_we)  a_q      <= rf_rd1;
         if (cs.ab_we)  b_q      <= rf_rd2;
         if (cs.res_we) aluout_q <= alu_y;
         if (cs.mdr_we) mdr_q    <= mem_rdata;
      end
   end

   assign mem_addr  = cs.addr_res ? aluout_q : pc_q;
   assign mem_wdata = b_q;
   assign mem_we    = cs.mem_we;

endmodule

// File: rtl/mcdp_core_chk.sv
module mcdp_core_chk
   import mcdp_pkg::*;
#(
   parameter bit R0Z = 1'b1
) (
   input logic        clk,
   input logic        rst_n,
   input state_e      state,
   input logic [31:0] pc,
   input logic [31:0] ir,
   input logic [31:0] a,
   input logic [31:0] aluout,
   input logic [31:0] rd1,
   input logic        alu_zero,
   input logic [31:0] mem_addr,
   input logic        mem_we
);

   // R5: every fetch advances the program counter by one word
   p_fetch_inc_r5: assert property (@(posedge clk) disable iff (!rst_n)
      state == ST_FETCH |=> pc == $past(pc) + 32'd4);

   // R5: write-back only directly after execute or the memory step
   p_wb_follows_exec_r5: assert property (@(posedge clk) disable iff (!rst_n)
      state == ST_WB |-> ($past(state) == ST_EXEC || $past(state) == ST_MEM));

   // R5: operand register A changes only when latched in the read cycle
   p_a_held_r5: assert property (@(posedge clk) disable iff (!rst_n)
      state != ST_DECODE |=> $stable(a));

   // R6: an unequal compare on beq leaves the program counter alone
   p_beq_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_EXEC && ir[31:26] == OP_BEQ && !alu_zero) |=> pc == $past(pc));

   // R8: jump keeps the upper nibble and inserts the target field
   p_jump_target_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_EXEC && ir[31:26] == OP_JMP)
      |=> pc == {$past(pc[31:28]), $past(ir[25:0]), 2'b00});

   // R10: the store strobe comes right after execute, on the computed address
   p_store_cycle_r10: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> ($past(state) == ST_EXEC && mem_addr == aluout && ir[31:26] == OP_STW));

   // R11: register 0 reads as zero when it is the rs source
   p_r0_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (R0Z && state == ST_DECODE && ir[25:21] == 5'd0) |-> rd1 == 32'd0);

endmodule

bind mcdp_core mcdp_core_chk #(.R0Z(R0_IS_ZERO)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .state    (st_q),
   .pc       (pc_q),
   .ir       (ir_q),
   .a        (a_q),
   .aluout   (aluout_q),
   .rd1      (rf_rd1),
   .alu_zero (alu_zero),
   .mem_addr (mem_addr),
   .mem_we   (mem_we)
);

// File: tb/sim_mcdp_core.sv
module sim_mcdp_core;

   localparam logic [31:0] BASE = 32'h1000_0000;
   localparam logic [5:0]  OPB  = 6'b000100;
   localparam logic [5:0]  OPN  = 6'b000101;
   localparam logic [5:0]  OPJ  = 6'b000010;
   localparam logic [5:0]  OPL  = 6'b100011;
   localparam logic [5:0]  OPS  = 6'b101011;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] mem_addr, mem_wdata, mem_rdata;
   logic        mem_we;
   logic [31:0] mem [256];
   int          cyc = 0;
   int          n_run = 0;
   int          n_fail = 0;
   bit          done = 1'b0;

   always #4 clk = ~clk;

   mcdp_core #(.REG_CNT(32), .PC_RESET(BASE), .R0_IS_ZERO(1'b1)) u0 (
      .clk       (clk),
      .rst_n     (rst_n),
      .mem_addr  (mem_addr),
      .mem_wdata (mem_wdata),
      .mem_rdata (mem_rdata),
      .mem_we    (mem_we)
   );

   assign mem_rdata = mem[mem_addr[9:2]];

   always @(posedge clk) begin
      if (mem_we) mem[mem_addr[9:2]] <= mem_wdata;
      if (!rst_n) cyc <= 0;
      else        cyc <= cyc + 1;
   end

   function automatic logic [31:0] enc_i(input logic [5:0] op, input int rs, input int rt,
                                         input logic [15:0] imm);
      return {op, 5'(rs), 5'(rt), imm};
   endfunction

   function automatic logic [31:0] enc_alui(input logic [2:0] f, input int rs, input int rt,
                                            input logic [15:0] imm);
      return {3'b001, f, 5'(rs), 5'(rt), imm};
   endfunction

   function automatic logic [31:0] enc_r(input logic [2:0] f, input int rs, input int rt,
                                         input int rd, input logic [4:0] sh);
      return {6'd0, 5'(rs), 5'(rt), 5'(rd), sh, 3'b000, f};
   endfunction

   function automatic logic [31:0] enc_j(input logic [31:0] addr);
      return {OPJ, addr[27:2]};
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic clear_mem();
      for (int i = 0; i < 256; i++) mem[i] = 32'd0;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic at_cyc(input int c);
      while (cyc < c) @(negedge clk);
   endtask

   // R1: reset state
   task automatic t_reset();
      clear_mem();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      chk("R1 addr in reset", mem_addr, BASE);
      chk("R1 we in reset", {31'd0, mem_we}, 32'd0);
      rst_n = 1'b1;
      chk("R1 addr after reset", mem_addr, BASE);
      chk("R1 we after reset", {31'd0, mem_we}, 32'd0);
   endtask

   // R2 R3 R4 R11 R12: arithmetic, immediates, shifts, register 0, undefined opcode
   task automatic t_alu_ops();
      logic [31:0] exp [12];
      string       tag [12];
      clear_mem();
      mem[0]  = enc_alui(3'b010, 0, 1, 16'd5);
      mem[1]  = enc_alui(3'b010, 0, 2, 16'hFFFD);
      mem[2]  = enc_r(3'b010, 1, 2, 3, 5'd0);
      mem[3]  = enc_r(3'b110, 1, 2, 4, 5'd0);
      mem[4]  = enc_alui(3'b000, 1, 5, 16'd12);
      mem[5]  = enc_alui(3'b001, 1, 6, 16'd8);
      mem[6]  = enc_r(3'b101, 1, 0, 7, 5'd7);
      mem[7]  = enc_r(3'b111, 2, 0, 8, 5'd3);
      mem[8]  = {6'b111111, 5'd0, 5'd1, 16'hFFFF};
      mem[9]  = enc_alui(3'b010, 0, 0, 16'd7);
      mem[10] = enc_alui(3'b011, 1, 10, 16'h00FF);
      mem[11] = enc_alui(3'b101, 2, 11, 16'd0);
      for (int k = 0; k < 12; k++) mem[12 + k] = enc_i(OPS, 0, k, 16'(32'h100 + 4 * k));
      mem[24] = enc_j(BASE + 32'd96);
      exp[0] = 32'd0;          tag[0] = "R11 r0 write discarded";
      exp[1] = 32'd5;          tag[1] = "R12 undefined opcode left r1";
      exp[2] = 32'hFFFF_FFFD;  tag[2] = "R3 sign-extended add";
      exp[3] = 32'd2;          tag[3] = "R2 register add";
      exp[4] = 32'd8;          tag[4] = "R2 register subtract";
      exp[5] = 32'd4;          tag[5] = "R3 immediate and";
      exp[6] = 32'd13;         tag[6] = "R3 immediate or";
      exp[7] = 32'd10;         tag[7] = "R4 shift left ignores shamt";
      exp[8] = 32'h7FFF_FFFE;  tag[8] = "R4 logical shift right";
      exp[9] = 32'd0;          tag[9] = "R1 untouched register is zero";
      exp[10] = 32'd0;         tag[10] = "R2 unused code gives zero";
      exp[11] = 32'hFFFF_FFFA; tag[11] = "R3 immediate shift";
      do_reset();
      at_cyc(120);
      for (int k = 0; k < 12; k++) chk(tag[k], mem[64 + k], exp[k]);
   endtask

   // R5 R6 R7 R10: branch timing and store cycle
   task automatic t_branches();
      clear_mem();
      mem[0]  = enc_alui(3'b010, 0, 3, 16'h44);
      mem[1]  = enc_alui(3'b010, 0, 1, 16'd1);
      mem[2]  = enc_alui(3'b010, 0, 2, 16'd1);
      mem[3]  = enc_i(OPB, 1, 2, 16'd2);
      mem[4]  = enc_alui(3'b010, 0, 3, 16'h11);
      mem[5]  = enc_alui(3'b010, 0, 3, 16'h22);
      mem[6]  = enc_i(OPN, 1, 2, 16'd5);
      mem[7]  = enc_alui(3'b010, 0, 4, 16'h33);
      mem[8]  = enc_i(OPS, 0, 4, 16'h100);
      mem[9]  = enc_i(OPS, 0, 3, 16'h104);
      mem[10] = enc_i(OPN, 1, 0, 16'd1);
      mem[11] = enc_i(OPS, 0, 1, 16'h108);
      mem[12] = enc_i(OPB, 1, 0, 16'd5);
      mem[13] = enc_i(OPB, 0, 0, 16'hFFFF);
      do_reset();
      at_cyc(14);
      chk("R6 beq execute cycle addr", mem_addr, BASE + 32'd16);
      at_cyc(15);
      chk("R6 beq taken next fetch", mem_addr, BASE + 32'd24);
      at_cyc(18);
      chk("R7 bne not taken next fetch", mem_addr, BASE + 32'd28);
      at_cyc(22);
      chk("R5 immediate op four cycles", mem_addr, BASE + 32'd32);
      at_cyc(24);
      chk("R10 no strobe in execute", {31'd0, mem_we}, 32'd0);
      at_cyc(25);
      chk("R10 strobe in fourth cycle", {31'd0, mem_we}, 32'd1);
      chk("R10 store address", mem_addr, 32'h100);
      chk("R10 store data", mem_wdata, 32'h33);
      at_cyc(26);
      chk("R10 strobe drops", {31'd0, mem_we}, 32'd0);
      at_cyc(33);
      chk("R7 bne taken next fetch", mem_addr, BASE + 32'd48);
      at_cyc(36);
      chk("R6 beq not taken next fetch", mem_addr, BASE + 32'd52);
      at_cyc(42);
      chk("R6 backward beq to itself", mem_addr, BASE + 32'd52);
      chk("R6 skipped instructions", mem[65], 32'h44);
      chk("R7 skipped store", mem[66], 32'd0);
   endtask

   // R9: load word
   task automatic t_load();
      clear_mem();
      mem[129] = 32'hCAFE_F00D;
      mem[0] = enc_alui(3'b010, 0, 1, 16'h200);
      mem[1] = enc_i(OPL, 1, 2, 16'd4);
      mem[2] = enc_i(OPS, 1, 2, 16'hFFFC);
      mem[3] = enc_j(BASE + 32'd12);
      do_reset();
      at_cyc(7);
      chk("R9 load address", mem_addr, 32'h204);
      chk("R9 no strobe on load", {31'd0, mem_we}, 32'd0);
      at_cyc(9);
      chk("R9 load five cycles", mem_addr, BASE + 32'd8);
      at_cyc(20);
      chk("R9 loaded word stored back", mem[127], 32'hCAFE_F00D);
   endtask

   // R8: jump
   task automatic t_jump();
      clear_mem();
      mem[0] = enc_j(BASE + 32'd16);
      mem[1] = enc_alui(3'b010, 0, 5, 16'h66);
      mem[4] = enc_alui(3'b010, 0, 5, 16'h55);
      mem[5] = enc_i(OPS, 0, 5, 16'h108);
      mem[6] = enc_j(BASE + 32'd24);
      do_reset();
      at_cyc(2);
      chk("R8 jump execute cycle addr", mem_addr, BASE + 32'd4);
      at_cyc(3);
      chk("R8 jump keeps upper nibble", mem_addr, BASE + 32'd16);
      at_cyc(20);
      chk("R8 jump skipped instruction", mem[66], 32'h55);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      t_reset();
      t_alu_ops();
      t_branches();
      t_load();
      t_jump();
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule